// File: doc/BRIEF.md
# SPI Slave Serial Front End with Suspend

This block is the pin-side half of an SPI memory slave. A fast system clock samples the four serial pins: chip select, serial clock, serial data in and the active-low suspend input. The block finds serial clock edges in the system clock domain and assembles incoming bits into bytes. It hands each finished byte to a command engine, which decodes it. When the engine decides that the transfer has become a read, the block switches to transmit mode for the rest of the selection. From then on it shifts bytes from the engine out on serial data out and drives the output enable of that pin.

Input bits are always taken on falling serial clock edges, and output bits are always launched after rising edges. This holds whether the serial clock rests low or rests high between transfers, so both idle polarities work with no configuration. The suspend input freezes the bit sequence so that a master can pause the transfer and later resume it at the exact bit where it stopped. Entry into and exit from suspend are both gated by the serial clock level. The output enable drops as soon as the synchronized suspend input goes low.

The serial clock must run at no more than one quarter of the system clock rate. The engine has to answer each byte-boundary strobe on the following system cycle.

Top module: `spi_hold_frontend`

## Requirements
- R1: After reset, and whenever chip select is high, so_oe_o is low and rx_valid_o and tx_load_o are idle.
- R2: While selected and not suspended, each falling serial clock edge captures si_i. The first captured bit is the most significant. After DATA_W captures, rx_data_o carries the byte and rx_valid_o is high for exactly one system cycle.
- R3: In receive mode so_oe_o stays low for the whole selection.
- R4: Transfers that start and end with the serial clock resting low give the same bytes as transfers that start and end with it resting high.
- R5: tx_load_o pulses for one cycle at every byte boundary. If tx_en_i is high at the first rising edge after a boundary, the block enters transmit mode until deselect. On that edge it loads tx_data_i and drives its most significant bit on so_o with so_oe_o high. Each later rising edge drives the next bit, and each new boundary starts the next byte from tx_data_i.
- R6: In transmit mode si_i is ignored and rx_valid_o never pulses.
- R7: Suspend starts at once if hold_n_i falls while the serial clock is high. If it falls while the clock is low, suspend starts at the next rising edge, and that rising edge is still processed.
- R8: While suspended, serial clock and si_i activity changes neither the bit position nor the shift contents. The transfer resumes at the same bit.
- R9: Suspend ends at once if hold_n_i rises while the serial clock is high. If it rises while the clock is low, suspend ends at the next rising edge, and that edge is not processed.
- R10: hold_n_i low forces so_oe_o low within SYNC_STAGES+1 system cycles, whatever the serial clock level.
- R11: Chip select high clears the bit position, the suspend state and transmit mode, so the next selection starts a fresh byte in receive mode.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, at least 4x the serial clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n_i | input | 1 | Chip select pin, active low |
| sck_i | input | 1 | Serial clock pin |
| si_i | input | 1 | Serial data in pin |
| hold_n_i | input | 1 | Suspend pin, active low |
| tx_en_i | input | 1 | Engine request to switch to transmit mode |
| tx_data_i | input | DATA_W | Next byte to send, valid the cycle after tx_load_o |
| rx_data_o | output | DATA_W | Last received byte |
| rx_valid_o | output | 1 | One-cycle strobe for rx_data_o |
| tx_load_o | output | 1 | One-cycle byte-boundary strobe |
| so_o | output | 1 | Serial data out value |
| so_oe_o | output | 1 | Output enable for serial data out (low = high impedance) |

## Verification
On every cycle, the assertions check four things. The suspend state changes only when the serial clock level allows it. The bit position and shift registers stay frozen while suspended. Deselect clears the bit position, the mode and the output enable. The output enable stays low in receive mode and receive strobes stop in transmit mode. Only the bench scenarios can show the data behaviour end to end. These cover correct bytes in both idle polarities, the handover to transmit after the address byte, and whether the rising edge at suspend entry is processed and the one at suspend exit is dropped. They also show that a read resumes on the right bit after each kind of suspend.

// File: rtl/spi_fe_pkg.sv
package spi_fe_pkg;

   typedef struct packed {
      logic cs_n;
      logic sck;
      logic si;
      logic hold_n;
   } spi_pins_t;

   localparam spi_pins_t PIN_IDLE = '{cs_n: 1'b1, sck: 1'b0, si: 1'b0, hold_n: 1'b1};

   typedef enum logic {
      XF_RX = 1'b0,
      XF_TX = 1'b1
   } xfer_mode_t;

endpackage

// File: rtl/spi_fe_sync.sv
module spi_fe_sync #(
   parameter int              WIDTH   = 4,
   parameter int              STAGES  = 2,
   parameter logic [WIDTH-1:0] RST_VAL = '0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d,
   output logic [WIDTH-1:0] q
);
   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("spi_fe_sync: STAGES must be at least 2");
      end
   endgenerate

   logic [WIDTH-1:0] chain [STAGES];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < STAGES; i++) chain[i] <= RST_VAL;
      end else begin
         chain[0] <= d;
         for (int i = 1; i < STAGES; i++) chain[i] <= chain[i-1];
      end
   end

   assign q = chain[STAGES-1];
endmodule

// File: rtl/spi_fe_hold.sv
module spi_fe_hold (
   input  logic clk,
   input  logic rst_n,
   input  logic cs_n_s,
   input  logic sck_s,
   input  logic hold_n_s,
   output logic held_o
);
   logic held_q;

   // Suspend state follows the pin only while the serial clock is high.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       held_q <= 1'b0;
      else if (cs_n_s)  held_q <= 1'b0;
      else if (sck_s)   held_q <= ~hold_n_s;
   end

   assign held_o = held_q;

   p_hold_entry_r7: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(held_q) |-> $past(sck_s && !hold_n_s && !cs_n_s));

   p_hold_exit_r9: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(held_q) |-> $past(cs_n_s || (sck_s && hold_n_s)));
endmodule

// File: rtl/spi_fe_shift.sv
module spi_fe_shift
   import spi_fe_pkg::*;
#(
   parameter int DATA_W    = 8,
   parameter bit MSB_FIRST = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cs_n_s,
   input  logic              sck_s,
   input  logic              si_s,
   input  logic              hold_n_s,
   input  logic              held_i,
   input  logic              tx_en_i,
   input  logic [DATA_W-1:0] tx_data_i,
   output logic [DATA_W-1:0] rx_data_o,
   output logic              rx_valid_o,
   output logic              tx_load_o,
   output logic              so_o,
   output logic              so_oe_o
);
   localparam int               CNT_W = (DATA_W > 2) ? $clog2(DATA_W) : 1;
   localparam logic [CNT_W-1:0] LAST  = CNT_W'(DATA_W - 1);

   generate
      if (DATA_W < 2) begin : g_bad_width
         $error("spi_fe_shift: DATA_W must be at least 2");
      end
   endgenerate

   logic              sck_q;
   logic [CNT_W-1:0]  bit_cnt;
   xfer_mode_t        mode;
   logic [DATA_W-2:0] rx_sh;
   logic [DATA_W-1:0] tx_sh;
   logic [DATA_W-1:0] rx_q;
   logic              rx_valid_q, tx_load_q, so_q, oe_q;

   logic              rise, fall, live;
   logic [DATA_W-1:0] rx_next, rx_ord, tx_ord;

   assign rise    = sck_s & ~sck_q;
   assign fall    = ~sck_s & sck_q;
   assign live    = ~cs_n_s & ~held_i;
   assign rx_next = {rx_sh, si_s};

   // The shifters work first bit first; the bit order is mapped at the byte edge.
   generate
      if (MSB_FIRST) begin : g_msb
         assign rx_ord = rx_next;
         assign tx_ord = tx_data_i;
      end else begin : g_lsb
         for (genvar i = 0; i < DATA_W; i++) begin : g_rev
            assign rx_ord[i] = rx_next[DATA_W-1-i];
            assign tx_ord[i] = tx_data_i[DATA_W-1-i];
         end
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sck_q      <= 1'b0;
         bit_cnt    <= '0;
         mode       <= XF_RX;
         rx_sh      <= '0;
         tx_sh      <= '0;
         rx_q       <= '0;
         rx_valid_q <= 1'b0;
         tx_load_q  <= 1'b0;
         so_q       <= 1'b0;
         oe_q       <= 1'b0;
      end else begin
         sck_q      <= sck_s;
         rx_valid_q <= 1'b0;
         tx_load_q  <= 1'b0;
         if (cs_n_s) begin
            bit_cnt <= '0;
            mode    <= XF_RX;
            oe_q    <= 1'b0;
         end else if (live) begin
            if (fall) begin
               bit_cnt <= (bit_cnt == LAST) ? '0 : bit_cnt + 1'b1;
               if (mode == XF_RX) rx_sh <= rx_next[DATA_W-2:0];
               if (bit_cnt == LAST) begin
                  tx_load_q <= 1'b1;
                  if (mode == XF_RX) begin
                     rx_valid_q <= 1'b1;
                     rx_q       <= rx_ord;
                  end
               end
            end
            if (rise) begin
               if (bit_cnt == '0 && (mode == XF_TX || tx_en_i)) begin
                  mode  <= XF_TX;
                  oe_q  <= 1'b1;
                  so_q  <= tx_ord[DATA_W-1];
                  tx_sh <= {tx_ord[DATA_W-2:0], 1'b0};
               end else if (mode == XF_TX) begin
                  so_q  <= tx_sh[DATA_W-1];
                  tx_sh <= {tx_sh[DATA_W-2:0], 1'b0};
               end
            end
         end
      end
   end

   assign rx_data_o  = rx_q;
   assign rx_valid_o = rx_valid_q;
   assign tx_load_o  = tx_load_q;
   assign so_o       = so_q;
   assign so_oe_o    = oe_q & ~held_i & hold_n_s & ~cs_n_s;

   p_freeze_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (held_i && !cs_n_s) |=> ($stable(bit_cnt) && $stable(rx_sh) && $stable(tx_sh) && $stable(so_q)));

   p_deselect_r11: assert property (@(posedge clk) disable iff (!rst_n)
      cs_n_s |=> (bit_cnt == '0 && mode == XF_RX && !oe_q));

   p_rx_hiz_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (mode == XF_RX) |-> !so_oe_o);

   p_no_rx_in_tx_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (mode == XF_TX) |=> !rx_valid_q);

   p_valid_pulse_r2: assert property (@(posedge clk) disable iff (!rst_n)
      rx_valid_q |=> !rx_valid_q);
endmodule

// File: rtl/spi_hold_frontend.sv
module spi_hold_frontend
   import spi_fe_pkg::*;
#(
   parameter int DATA_W      = 8,
   parameter int SYNC_STAGES = 2,
   parameter bit MSB_FIRST   = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cs_n_i,
   input  logic              sck_i,
   input  logic              si_i,
   input  logic              hold_n_i,
   input  logic              tx_en_i,
   input  logic [DATA_W-1:0] tx_data_i,
   output logic [DATA_W-1:0] rx_data_o,
   output logic              rx_valid_o,
   output logic              tx_load_o,
   output logic              so_o,
   output logic              so_oe_o
);
   localparam int PIN_W = $bits(spi_pins_t);

   spi_pins_t raw, syn;
   logic      held;

   assign raw = '{cs_n: cs_n_i, sck: sck_i, si: si_i, hold_n: hold_n_i};

   spi_fe_sync #(
      .WIDTH   (PIN_W),
      .STAGES  (SYNC_STAGES),
      .RST_VAL (PIN_IDLE)
   ) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     (raw),
      .q     (syn)
   );

   spi_fe_hold u_hold (
      .clk      (clk),
      .rst_n    (rst_n),
      .cs_n_s   (syn.cs_n),
      .sck_s    (syn.sck),
      .hold_n_s (syn.hold_n),
      .held_o   (held)
   );

   spi_fe_shift #(
      .DATA_W    (DATA_W),
      .MSB_FIRST (MSB_FIRST)
   ) u_shift (
      .clk        (clk),
      .rst_n      (rst_n),
      .cs_n_s     (syn.cs_n),
      .sck_s      (syn.sck),
      .si_s       (syn.si),
      .hold_n_s   (syn.hold_n),
      .held_i     (held),
      .tx_en_i    (tx_en_i),
      .tx_data_i  (tx_data_i),
      .rx_data_o  (rx_data_o),
      .rx_valid_o (rx_valid_o),
      .tx_load_o  (tx_load_o),
      .so_o       (so_o),
      .so_oe_o    (so_oe_o)
   );
endmodule

// File: tb/tb_spi_hold_frontend.sv
module tb_spi_hold_frontend;
   localparam int H = 6;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #5 clk = ~clk;

   logic       cs_n = 1'b1, sck = 1'b0, si = 1'b0, hold_n = 1'b1, tx_en = 1'b0;
   logic [7:0] tx_data = 8'h00;
   logic [7:0] rx_data;
   logic       rx_valid, tx_load, so, so_oe;

   spi_hold_frontend dut (
      .clk(clk), .rst_n(rst_n), .cs_n_i(cs_n), .sck_i(sck), .si_i(si),
      .hold_n_i(hold_n), .tx_en_i(tx_en), .tx_data_i(tx_data),
      .rx_data_o(rx_data), .rx_valid_o(rx_valid), .tx_load_o(tx_load),
      .so_o(so), .so_oe_o(so_oe));

   int n_chk = 0, n_bad = 0;
   logic [7:0] rx_log [64];
   int rx_cnt = 0;
   int oe_bad = 0;
   logic watch_hiz = 1'b0;
   int eng_after = 0, eng_seen = 0, tx_idx = 0;
   logic [7:0] tx_q [8];
   logic done = 1'b0;

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic wait_clk(input int n);
      repeat (n) @(posedge clk);
      #1;
   endtask

   // Monitor and command-engine model, evaluated away from the active edge.
   initial forever begin
      @(negedge clk);
      if (watch_hiz && so_oe) oe_bad++;
      if (rx_valid) begin
         rx_log[rx_cnt % 64] = rx_data;
         rx_cnt++;
      end
      if (cs_n) begin
         tx_en    = 1'b0;
         eng_seen = 0;
      end else if (rx_valid) begin
         eng_seen++;
         if (eng_after != 0 && eng_seen == eng_after) begin
            tx_en   = 1'b1;
            tx_data = tx_q[0];
            tx_idx  = 1;
         end
      end else if (tx_load && tx_en) begin
         tx_data = tx_q[tx_idx % 8];
         tx_idx++;
      end
   end

   task automatic bit_cyc(input logic b, output logic s);
      sck = 1'b1; si = b;
      wait_clk(H);
      s = so;
      sck = 1'b0;
      wait_clk(H);
   endtask

   task automatic xfer(input logic [7:0] d, output logic [7:0] r);
      for (int i = 7; i >= 0; i--) bit_cyc(d[i], r[i]);
   endtask

   task automatic begin_sel(input logic idle_high);
      sck = idle_high;
      wait_clk(4);
      cs_n = 1'b0;
      wait_clk(4);
   endtask

   task automatic end_sel(input logic idle_high);
      if (idle_high) begin
         sck = 1'b1;
         wait_clk(H);
      end
      cs_n = 1'b1;
      wait_clk(6);
      check("R1 oe after deselect", so_oe, 1'b0);
      sck = 1'b0;
      wait_clk(4);
   endtask

   task automatic t_reset();
      check("R1 reset so_oe", so_oe, 1'b0);
      check("R1 reset rx_valid", rx_valid, 1'b0);
      check("R1 reset tx_load", tx_load, 1'b0);
   endtask

   task automatic t_write(input logic idle_high);
      logic [7:0] r;
      int base = rx_cnt;
      oe_bad = 0;
      watch_hiz = 1'b1;
      begin_sel(idle_high);
      xfer(8'hA5, r);
      xfer(8'h3C, r);
      xfer(8'h81, r);
      watch_hiz = 1'b0;
      end_sel(idle_high);
      check(idle_high ? "R4 idle-high byte count" : "R2 idle-low byte count", rx_cnt - base, 3);
      check("R2 byte0 R4", rx_log[base % 64], 8'hA5);
      check("R2 byte1 R4", rx_log[(base + 1) % 64], 8'h3C);
      check("R2 byte2 R4", rx_log[(base + 2) % 64], 8'h81);
      check("R3 so_oe low in receive", oe_bad, 0);
   endtask

   task automatic t_read(input logic idle_high);
      logic [7:0] r;
      int base = rx_cnt;
      int oe_low = 0;
      tx_q[0] = 8'hC3; tx_q[1] = 8'h5E; tx_q[2] = 8'h0F;
      eng_after = 2;
      oe_bad = 0;
      watch_hiz = 1'b1;
      begin_sel(idle_high);
      xfer(8'h03, r);
      xfer(8'h10, r);
      watch_hiz = 1'b0;
      check("R3 hi-z during command", oe_bad, 0);
      for (int k = 0; k < 3; k++) begin
         for (int i = 7; i >= 0; i--) begin
            sck = 1'b1; si = i[0];
            wait_clk(H);
            r[i] = so;
            if (!so_oe) oe_low++;
            sck = 1'b0;
            wait_clk(H);
         end
         check("R5 read byte", r, tx_q[k]);
      end
      check("R5 so_oe driven in transmit", oe_low, 0);
      check("R6 no rx strobe while sending", rx_cnt - base, 2);
      end_sel(idle_high);
      eng_after = 0;
   endtask

   task automatic t_hold_rx();
      logic [7:0] r;
      logic [7:0] d = 8'h96;
      int base = rx_cnt;
      begin_sel(1'b0);
      for (int i = 7; i >= 4; i--) bit_cyc(d[i], r[i]);
      sck = 1'b1; si = d[3];
      wait_clk(H);
      hold_n = 1'b0;                  // entry with clock high
      wait_clk(4);
      for (int k = 0; k < 2; k++) begin
         sck = 1'b0; si = ~d[3];
         wait_clk(H);
         sck = 1'b1;
         wait_clk(H);
      end
      hold_n = 1'b1;                  // release with clock high
      wait_clk(4);
      check("R8 no strobe while suspended", rx_cnt - base, 0);
      si = d[3];
      wait_clk(H);
      sck = 1'b0;
      wait_clk(H);
      for (int i = 2; i >= 0; i--) bit_cyc(d[i], r[i]);
      xfer(8'h42, r);
      end_sel(1'b0);
      check("R8 byte count after suspend", rx_cnt - base, 2);
      check("R8 byte resumed intact R7", rx_log[base % 64], 8'h96);
      check("R8 next byte aligned", rx_log[(base + 1) % 64], 8'h42);
   endtask

   task automatic t_read_hold();
      logic [7:0] r;
      logic [7:0] exp0 = 8'hB4;
      tx_q[0] = exp0; tx_q[1] = 8'h6D;
      eng_after = 2;
      begin_sel(1'b0);
      xfer(8'h03, r);
      xfer(8'h20, r);
      for (int i = 7; i >= 5; i--) bit_cyc(1'b0, r[i]);
      // bit 4: suspend while high, release while low
      sck = 1'b1;
      wait_clk(H);
      r[4] = so;
      hold_n = 1'b0;
      wait_clk(4);
      check("R10 tristate on suspend (clock high)", so_oe, 1'b0);
      sck = 1'b0;
      wait_clk(H);
      hold_n = 1'b1;
      wait_clk(H);
      check("R9 still suspended until rising edge", so_oe, 1'b0);
      sck = 1'b1;                     // exit edge, must not shift
      wait_clk(H);
      check("R9 exit edge not processed", so, exp0[4]);
      check("R9 driven after exit", so_oe, 1'b1);
      sck = 1'b0;
      wait_clk(H);
      // bit 3: suspend while low, release while high
      hold_n = 1'b0;
      wait_clk(3);
      check("R10 tristate on suspend (clock low)", so_oe, 1'b0);
      sck = 1'b1;                     // entry edge, still shifts
      wait_clk(H);
      sck = 1'b0; si = 1'b1;
      wait_clk(H);
      sck = 1'b1;
      wait_clk(H);
      hold_n = 1'b1;
      wait_clk(H);
      r[3] = so;
      check("R7 entry edge processed", so_oe, 1'b1);
      sck = 1'b0;
      wait_clk(H);
      for (int i = 2; i >= 0; i--) bit_cyc(1'b1, r[i]);
      check("R7 R8 read byte across suspends", r, exp0);
      xfer(8'hFF, r);
      check("R8 following byte aligned", r, 8'h6D);
      end_sel(1'b0);
      eng_after = 0;
   endtask

   task automatic t_deselect();
      logic [7:0] r;
      int base = rx_cnt;
      begin_sel(1'b0);
      bit_cyc(1'b1, r[0]);
      bit_cyc(1'b0, r[0]);
      bit_cyc(1'b1, r[0]);
      sck = 1'b1;
      wait_clk(H);
      hold_n = 1'b0;
      wait_clk(4);
      cs_n = 1'b1;
      wait_clk(4);
      hold_n = 1'b1;
      sck = 1'b0;
      wait_clk(6);
      check("R11 so_oe low after abort", so_oe, 1'b0);
      begin_sel(1'b0);
      xfer(8'h5B, r);
      end_sel(1'b0);
      check("R11 fresh byte count", rx_cnt - base, 1);
      check("R11 fresh byte value", rx_log[base % 64], 8'h5B);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_chk++;
         n_bad++;
         $display("FAIL watchdog: run did not finish");
         $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
         $finish;
      end
   end

   initial begin
      wait_clk(5);
      rst_n = 1'b1;
      wait_clk(3);
      t_reset();
      t_write(1'b0);
      t_write(1'b1);
      t_read(1'b0);
      t_read(1'b1);
      t_hold_rx();
      t_read_hold();
      t_deselect();
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end
endmodule